// File: doc/BRIEF.md
# DDR Bus Multi-Pattern Error Checker

This block sits behind the capture flops of an 8-bit double-data-rate bus. Each clock cycle delivers two captured words, one from the rising edge and one from the falling edge. When checking is live, the block compares each word against one of eight programmable reference words. It takes the reference words in a fixed rotation and accumulates any disagreement into a sticky per-bit error mask. A set bit in the mask names a data lane that was wrong at least once, whichever reference slot exposed it. The mask is therefore the input a bring-up routine needs when it retunes a lane delay or a sampling phase and then repeats the run.

Software reaches the block through a small register port. Register addresses below the slot count hold the reference words, and each reference word starts at a walking-zero value. One register arms the checker. A second register starts a run when 0x00 is written to it. A third register holds the error mask, and writing 0x00 to it clears the mask. An alignment marker that arrives with a captured pair restarts the reference rotation, so the sender and the checker agree on which reference word belongs to which captured word.

Top module: `ddr_pattern_check`

## Requirements
- R1: After reset, reference slot k reads ~(1 << k) (slot 0 = 0xFE through slot 7 = 0x7F), the error mask (address 10) reads 0x00, and the arm register (address 8) and the run register (address 9) read 0x00.
- R2: A register write with address k in 0..7 replaces reference slot k from the next cycle on. The new value reads back at address k and is used by every later comparison against slot k.
- R3: Comparisons take place only while the arm bit (bit 0 of address 8) is 1 and the run flag is set. Writing 0x00 to address 9 sets the run flag and writing any non-zero value clears it. Either write takes effect in the cycle after the write.
- R4: On every cycle with capture valid, the rising word is compared with slot s and the falling word with slot s+1 (mod 8), and s then advances by 2 (mod 8).
- R5: When the alignment marker is high on a valid cycle, that cycle's rising word uses slot 0 and its falling word uses slot 1, whatever the previous slot was. The next valid cycle starts at slot 2.
- R6: Bit n of the error mask is set in the cycle after a captured word disagrees with its reference word on bit n, whether the word is rising or falling and whatever its slot.
- R7: Error mask bits are sticky. A set bit stays 1 through later matching words until it is cleared.
- R8: Writing 0x00 to address 10 clears the mask and writing a non-zero value leaves it unchanged. Mismatches found in the same cycle as a clear still appear in the mask afterwards.
- R9: While comparisons are off, the mask holds its value. The slot index still advances with every valid captured pair, so alignment is kept across a pause.
- R10: Address 8 reads {7'b0, arm} and address 9 reads {7'b0, run flag}. Addresses 11 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock of the captured bus |
| rstN | input | 1 | Asynchronous reset, active low |
| capValid | input | 1 | A captured rising/falling pair is present this cycle |
| frameMark | input | 1 | Alignment marker; restarts the slot rotation on a valid cycle |
| capRise | input | 8 | Word captured on the rising edge |
| capFall | input | 8 | Word captured on the falling edge |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data at regAddr |

## Verification
The bench builds the block with its default parameters: an 8-bit word, eight reference slots and a 4-bit register address. With these values the rotation wraps from slot 7 back to slot 0 inside a run of valid cycles. All 16 addresses, including the five unmapped ones, can be reached from the register port. A directed phase covers re-alignment from a mid-rotation slot, a clear in the same cycle as a mismatch, and a pause in which the slot index must keep moving. A long stretch follows with random pattern rewrites, arm and run toggling, clears and single-bit corruptions.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Strobes handed from the control to the datapath every cycle
  typedef struct packed {
    logic patWr;       // register write aimed at a reference slot
    logic maskClr;     // zero written to the error mask register
    logic checkEn;     // arm and run both set
    logic capture;     // a captured pair is present
    logic frameAlign;  // alignment marker on a captured pair
  } dpcStrobes_t;

endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              capValid,
  input  logic              frameMark,
  output dpcStrobes_t       strobes,
  output logic              armQ,
  output logic              runQ
);

  localparam int ARM_ADDR  = SLOTS;
  localparam int RUN_ADDR  = SLOTS + 1;
  localparam int MASK_ADDR = SLOTS + 2;

  logic armHit;
  logic runHit;
  logic maskHit;
  logic dataZero;

  assign armHit   = regWrEn && (regAddr == ADDR_W'(ARM_ADDR));
  assign runHit   = regWrEn && (regAddr == ADDR_W'(RUN_ADDR));
  assign maskHit  = regWrEn && (regAddr == ADDR_W'(MASK_ADDR));
  assign dataZero = (regWrData == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ <= 1'b0;
      runQ <= 1'b0;
    end else begin
      if (armHit) armQ <= regWrData[0];
      if (runHit) runQ <= dataZero;
    end
  end

  always_comb begin
    strobes.patWr      = regWrEn && (regAddr < ADDR_W'(SLOTS));
    strobes.maskClr    = maskHit && dataZero;
    strobes.checkEn    = armQ && runQ;
    strobes.capture    = capValid;
    strobes.frameAlign = capValid && frameMark;
  end

endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] capRise,
  input  logic [DATA_W-1:0] capFall,
  input  logic              armQ,
  input  logic              runQ,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] errMask,
  output logic [$clog2(SLOTS)-1:0] slotIdx
);

  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int ARM_ADDR  = SLOTS;
  localparam int RUN_ADDR  = SLOTS + 1;
  localparam int MASK_ADDR = SLOTS + 2;

  function automatic logic [DATA_W-1:0] defPat(input int k);
    return ~(DATA_W'(1) << (k % DATA_W));
  endfunction

  logic [SLOTS-1:0][DATA_W-1:0] patQ;
  logic [SLOT_W-1:0] riseSlot;
  logic [SLOT_W-1:0] fallSlot;
  logic [DATA_W-1:0] riseDiff;
  logic [DATA_W-1:0] fallDiff;
  logic [DATA_W-1:0] newErr;

  // Reference word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SLOTS; k++) patQ[k] <= defPat(k);
    end else if (strobes.patWr) begin
      patQ[regAddr[SLOT_W-1:0]] <= regWrData;
    end
  end

  // Slot rotation: two words per captured pair
  assign riseSlot = strobes.frameAlign ? '0 : slotIdx;
  assign fallSlot = riseSlot + SLOT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
    end else if (strobes.capture) begin
      slotIdx <= riseSlot + SLOT_W'(2);
    end
  end

  // Per-lane mismatch, one comparator per edge
  assign riseDiff = capRise ^ patQ[riseSlot];
  assign fallDiff = capFall ^ patQ[fallSlot];
  assign newErr   = (strobes.checkEn && strobes.capture) ? (riseDiff | fallDiff) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errMask <= '0;
    end else begin
      errMask <= (strobes.maskClr ? '0 : errMask) | newErr;
    end
  end

  // Register read mux
  always_comb begin
    regRdData = '0;
    if (regAddr < ADDR_W'(SLOTS)) begin
      regRdData = patQ[regAddr[SLOT_W-1:0]];
    end else if (regAddr == ADDR_W'(ARM_ADDR)) begin
      regRdData = DATA_W'(armQ);
    end else if (regAddr == ADDR_W'(RUN_ADDR)) begin
      regRdData = DATA_W'(runQ);
    end else if (regAddr == ADDR_W'(MASK_ADDR)) begin
      regRdData = errMask;
    end
  end

endmodule

// File: rtl/ddr_pattern_check.sv
module ddr_pattern_check
  import dpc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,   // power of two, SLOTS + 3 <= 2**ADDR_W
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic              frameMark,
  input  logic [DATA_W-1:0] capRise,
  input  logic [DATA_W-1:0] capFall,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  localparam int SLOT_W = $clog2(SLOTS);

  dpcStrobes_t       strobes;
  logic              armQ;
  logic              runQ;
  logic [DATA_W-1:0] errMask;
  logic [SLOT_W-1:0] slotIdx;

  dpc_ctrl #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .capValid  (capValid),
    .frameMark (frameMark),
    .strobes   (strobes),
    .armQ      (armQ),
    .runQ      (runQ)
  );

  dpc_datapath #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .capRise   (capRise),
    .capFall   (capFall),
    .armQ      (armQ),
    .runQ      (runQ),
    .regRdData (regRdData),
    .errMask   (errMask),
    .slotIdx   (slotIdx)
  );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     capValid,
  input logic                     frameMark,
  input logic                     regWrEn,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [DATA_W-1:0]        regWrData,
  input logic [DATA_W-1:0]        regRdData,
  input logic [DATA_W-1:0]        errMask,
  input logic                     armQ,
  input logic                     runQ,
  input logic [$clog2(SLOTS)-1:0] slotIdx
);

  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int RUN_ADDR  = SLOTS + 1;
  localparam int MASK_ADDR = SLOTS + 2;

  logic clrReq;
  assign clrReq = regWrEn && (regAddr == ADDR_W'(MASK_ADDR)) && (regWrData == '0);

  // R7
  sticky_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrReq |=> ((errMask & $past(errMask)) == $past(errMask)));

  // R8
  clear_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !(armQ && runQ)) |=> (errMask == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrReq && !(armQ && runQ)) |=> $stable(errMask));

  // R5
  frame_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && frameMark) |=> (slotIdx == SLOT_W'(2)));

  // R4
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !frameMark) |=> (slotIdx == $past(slotIdx) + SLOT_W'(2)));

  // R3
  run_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(RUN_ADDR)) |=> (runQ == ($past(regWrData) == '0)));

  // R10
  always_comb begin
    if (rstN && (int'(regAddr) > MASK_ADDR)) begin
      unmapped_zero_chk: assert (regRdData == '0);
    end
  end

endmodule

bind ddr_pattern_check dpc_checker #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .capValid  (capValid),
  .frameMark (frameMark),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .errMask   (errMask),
  .armQ      (armQ),
  .runQ      (runQ),
  .slotIdx   (slotIdx)
);

// File: tb/tb_ddr_pattern_check.sv
module tb_ddr_pattern_check;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       capValid = 1'b0;
  logic       frameMark = 1'b0;
  logic [7:0] capRise = '0;
  logic [7:0] capFall = '0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;

  int checks = 0;
  int fails  = 0;

  ddr_pattern_check dut (
    .clk       (clk),
    .rstN      (rstN),
    .capValid  (capValid),
    .frameMark (frameMark),
    .capRise   (capRise),
    .capFall   (capFall),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [7:0] mPat [8];
  logic       mArm = 1'b0;
  logic       mRun = 1'b0;
  logic [7:0] mMask = '0;
  int         mSlot = 0;

  initial for (int k = 0; k < 8; k++) mPat[k] = ~(8'd1 << k);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 8; k++) mPat[k] = ~(8'd1 << k);
      mArm = 0; mRun = 0; mMask = '0; mSlot = 0;
    end else begin
      logic [7:0] hit;
      int rs;
      hit = '0;
      rs = frameMark ? 0 : mSlot;
      if (capValid) begin
        if (mArm && mRun) hit = (capRise ^ mPat[rs]) | (capFall ^ mPat[(rs + 1) % 8]);
        mSlot = (rs + 2) % 8;
      end
      if (regWrEn && regAddr == 4'd10 && regWrData == 8'h00) mMask = '0;
      mMask = mMask | hit;
      if (regWrEn) begin
        if (regAddr < 4'd8) mPat[regAddr] = regWrData;
        else if (regAddr == 4'd8) mArm = regWrData[0];
        else if (regAddr == 4'd9) mRun = (regWrData == 8'h00);
      end
    end
  end

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    if (a < 4'd8) return mPat[a];
    if (a == 4'd8) return {7'b0, mArm};
    if (a == 4'd9) return {7'b0, mRun};
    if (a == 4'd10) return mMask;
    return 8'h00;
  endfunction

  function automatic string reqOf(input logic [3:0] a);
    if (a < 4'd8) return "R2";
    if (a == 4'd8 || a == 4'd9) return "R3";
    if (a == 4'd10) return "R6";
    return "R10";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Model comparison on every clock
  always @(negedge clk) begin
    if (rstN) chk(reqOf(regAddr), regRdData, modelRead(regAddr));
  end

  task automatic drive(input logic we, input logic [3:0] a, input logic [7:0] d,
                       input logic v, input logic f, input logic [7:0] r, input logic [7:0] fl);
    regWrEn = we; regAddr = a; regWrData = d;
    capValid = v; frameMark = f; capRise = r; capFall = fl;
    @(negedge clk); #1;
    regWrEn = 0; capValid = 0; frameMark = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic cyc(input logic f, input logic [7:0] r, input logic [7:0] fl);
    drive(1'b0, regAddr, 8'h00, 1'b1, f, r, fl);
  endtask

  task automatic rdx(input logic [3:0] a, input logic [7:0] exp, input string req);
    regAddr = a; #1;
    chk(req, regRdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL R4: watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset values
    rdx(4'd0, 8'hFE, "R1"); rdx(4'd7, 8'h7F, "R1");
    rdx(4'd10, 8'h00, "R1"); rdx(4'd8, 8'h00, "R1"); rdx(4'd9, 8'h00, "R1");
    // R9 nothing recorded while off; slot 0 -> 4
    cyc(0, 8'h00, 8'h00); cyc(0, 8'h00, 8'h00);
    rdx(4'd10, 8'h00, "R9");
    // R3 armed but not running
    wr(4'd8, 8'h01); rdx(4'd8, 8'h01, "R10");
    cyc(0, 8'h00, 8'h00);
    rdx(4'd10, 8'h00, "R3");
    wr(4'd9, 8'h00); rdx(4'd9, 8'h01, "R10");
    // R4 / R5 full rotation with wrap
    cyc(1, 8'hFE, 8'hFD); cyc(0, 8'hFB, 8'hF7); cyc(0, 8'hEF, 8'hDF);
    cyc(0, 8'hBF, 8'h7F); cyc(0, 8'hFE, 8'hFD);
    rdx(4'd10, 8'h00, "R4");
    // R6 falling word error on slot 3, R7 sticky
    cyc(0, 8'hFB, 8'hE7); rdx(4'd10, 8'h10, "R6");
    cyc(0, 8'hEF, 8'hDF); rdx(4'd10, 8'h10, "R7");
    // R8 clear semantics
    wr(4'd10, 8'h55); rdx(4'd10, 8'h10, "R8");
    wr(4'd10, 8'h00); rdx(4'd10, 8'h00, "R8");
    drive(1'b1, 4'd10, 8'h00, 1'b1, 1'b0, 8'hBE, 8'h7F);
    rdx(4'd10, 8'h01, "R8");
    // R2 rewrite slot 4 and use it
    wr(4'd4, 8'h3C); rdx(4'd4, 8'h3C, "R2");
    wr(4'd10, 8'h00);
    cyc(1, 8'hFE, 8'hFD); cyc(0, 8'hFB, 8'hF7); cyc(0, 8'h3C, 8'hDF);
    rdx(4'd10, 8'h00, "R2");
    // R5 realign from slot 6, then unmarked pair at slot 2
    cyc(1, 8'hFE, 8'hFD); rdx(4'd10, 8'h00, "R5");
    cyc(0, 8'hFE, 8'hFD); rdx(4'd10, 8'h0F, "R5");
    // R9 pause: mask holds, slot keeps moving (4 -> 6)
    wr(4'd8, 8'h00);
    cyc(0, 8'h00, 8'h00); rdx(4'd10, 8'h0F, "R9");
    wr(4'd10, 8'h00); wr(4'd8, 8'h01);
    cyc(0, 8'hBF, 8'h7F); rdx(4'd10, 8'h00, "R9");
    // R10 unmapped, R3 run stop
    rdx(4'd15, 8'h00, "R10"); rdx(4'd11, 8'h00, "R10");
    wr(4'd9, 8'h01); rdx(4'd9, 8'h00, "R3");
    cyc(0, 8'h00, 8'h00); rdx(4'd10, 8'h00, "R3");
    // Random stretch, model compared every clock
    wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    for (int i = 0; i < 600; i++) begin
      logic f, v, we;
      logic [3:0] a;
      logic [7:0] d, r, fl;
      int rs;
      v  = ($urandom_range(0, 3) != 0);
      f  = ($urandom_range(0, 9) == 0);
      rs = f ? 0 : mSlot;
      r  = mPat[rs];
      fl = mPat[(rs + 1) % 8];
      if ($urandom_range(0, 11) == 0) r  = r  ^ (8'd1 << $urandom_range(0, 7));
      if ($urandom_range(0, 11) == 0) fl = fl ^ (8'd1 << $urandom_range(0, 7));
      we = ($urandom_range(0, 9) == 0);
      a  = 4'($urandom_range(0, 15));
      d  = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      if (a == 4'd8 && we) d = 8'h01;
      drive(we, a, d, v, f, r, fl);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule